// File: doc/BRIEF.md
# Factory Bad-Block Map Builder

After reset this block walks every erase block of a serial NAND array. For each block it asks an external page-read sequencer for one byte: the first spare byte of page 0. It records the block as bad when that byte is anything other than the erased value. The result is a one-bit-per-block map held in flops. While the scan runs, and after it finishes, the map also takes runtime reports of blocks whose program or erase failed. A reported block is added to the map as bad.

Other logic reads the map through a single-cycle lookup port. Until every block has been visited, the lookup port answers busy, so normal traffic cannot act on a half-built map. A saturating counter gives the number of distinct blocks currently held as bad.

With the default parameters the array has 2048 blocks of 64 pages. Each page has 2048 main bytes and 64 spare bytes.

Top module: `bad_block_map`

## Requirements
- R1: The scan requests blocks 0, 1, ..., NUM_BLOCKS-1 in order, one read per block. Each read uses row address = block × PAGES_PER_BLOCK (page 0) and column address = MAIN_BYTES (2048 by default, the first spare byte). `rd_req` stays high with a stable address until `rd_done` is sampled.
- R2: A returned marker of 0xFF leaves the block good. Any other byte value (for example 0x00, 0x7F, 0xF7, 0xFE) marks it bad.
- R3: Reset clears every map entry to good, drives `ready` low and `bad_count` to zero. The scan starts on the first cycle after reset with `rd_req` high.
- R4: `ready` goes high on the clock edge that samples the last block's `rd_done`, and stays high. From then on `rd_req` is low.
- R5: A lookup (`qry_valid` high for one cycle) produces `resp_valid` high on the next cycle. If `ready` was low when the lookup was sampled, `resp_busy`=1 and `resp_bad`=0. Otherwise `resp_busy`=0 and `resp_bad` gives the entry for `qry_blk`.
- R6: A runtime report (`mark_valid` with `mark_blk`) sets that entry bad, whether it arrives during or after the scan. Reporting a block that is already bad changes neither the map nor the count.
- R7: When a scan result and a runtime report hit the same entry in the same cycle, the entry ends bad and is counted once, even if the scan found it good. When they hit different entries in the same cycle, both become bad and both are counted.
- R8: `bad_count` equals the number of distinct bad entries and saturates at 2^CNT_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Marker read request to the page-read sequencer |
| rd_row | output | ROW_W (17) | Row (page) address of the requested read |
| rd_col | output | COL_W (12) | Column (byte) address of the requested read |
| rd_done | input | 1 | One-cycle pulse: marker byte is valid |
| rd_byte | input | 8 | Marker byte returned by the sequencer |
| mark_valid | input | 1 | Runtime program/erase failure report |
| mark_blk | input | BLK_W (11) | Block number of the failure report |
| qry_valid | input | 1 | Lookup request |
| qry_blk | input | BLK_W (11) | Block number to look up |
| resp_valid | output | 1 | Lookup answer valid |
| resp_bad | output | 1 | Looked-up block is bad |
| resp_busy | output | 1 | Lookup was made before the map was complete |
| ready | output | 1 | Scan of all blocks finished |
| bad_count | output | CNT_W (12) | Saturating count of bad blocks |

## Verification
The map bit and the count for a scanned block change on the same edge that samples `rd_done`. A runtime report takes effect on the edge that samples `mark_valid`. A lookup answer appears on the edge after `qry_valid`, and `ready` rises on the edge of the last `rd_done`.

The bench drives inputs and samples outputs on falling edges. The sequencer model checks that `ready` is still low on the falling edge where it presents the last byte, and high one falling edge later. Each lookup and report task holds its request for exactly one falling-edge interval and reads the result at the next falling edge, which is the first point after the responsible rising edge.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  typedef enum logic {
    SC_RUN  = 1'b0,
    SC_HOLD = 1'b1
  } scan_state_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // row address of page 0 inside a block
  function automatic int unsigned first_page_row(int unsigned blk, int unsigned pages);
    return blk * pages;
  endfunction

  // a marker flags a bad block unless it is fully erased
  function automatic logic marker_bad(logic [7:0] b);
    return b != ERASED_BYTE;
  endfunction

  // saturating add used by the bad-block counter
  function automatic int unsigned sat_add(int unsigned cur, int unsigned inc,
                                          int unsigned maxv);
    return (cur + inc > maxv) ? maxv : cur + inc;
  endfunction

endpackage

// File: rtl/bbm_scanner.sv
module bbm_scanner #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MAIN_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             rd_req,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  input  logic             rd_done,
  input  logic [7:0]       rd_byte,
  output logic             scan_set,
  output logic [BLK_W-1:0] scan_blk,
  output logic             ready
);
  import bbm_pkg::*;

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_state_e      state;
  logic [BLK_W-1:0] blk;
  logic             step;

  assign rd_req   = (state == SC_RUN);
  assign rd_row   = ROW_W'(first_page_row(32'(blk), PAGES_PER_BLOCK));
  assign rd_col   = COL_W'(MAIN_BYTES);
  assign step     = rd_req && rd_done;
  assign scan_set = step && marker_bad(rd_byte);
  assign scan_blk = blk;
  assign ready    = (state == SC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SC_RUN;
      blk   <= '0;
    end else if (step) begin
      if (blk == LAST_BLK) state <= SC_HOLD;
      else                 blk   <= blk + 1'b1;
    end
  end

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> $stable(rd_row));

  // R4
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

endmodule

// File: rtl/bbm_table.sv
module bbm_table #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_set,
  input  logic [BLK_W-1:0] scan_blk,
  input  logic             mark_valid,
  input  logic [BLK_W-1:0] mark_blk,
  input  logic             ready,
  input  logic             qry_valid,
  input  logic [BLK_W-1:0] qry_blk,
  output logic             resp_valid,
  output logic             resp_bad,
  output logic             resp_busy,
  output logic [1:0]       new_bad
);

  logic [NUM_BLOCKS-1:0] tbl;
  logic scan_new, mark_new, same_entry;

  assign same_entry = scan_set && mark_valid && (scan_blk == mark_blk);
  assign scan_new   = scan_set && !tbl[scan_blk];
  assign mark_new   = mark_valid && !tbl[mark_blk] && !same_entry;
  assign new_bad    = {1'b0, scan_new} + {1'b0, mark_new};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '0;
    end else begin
      if (scan_set)   tbl[scan_blk] <= 1'b1;
      if (mark_valid) tbl[mark_blk] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_bad   <= 1'b0;
      resp_busy  <= 1'b0;
    end else begin
      resp_valid <= qry_valid;
      resp_busy  <= qry_valid && !ready;
      resp_bad   <= qry_valid && ready && tbl[qry_blk];
    end
  end

  // R6
  mark_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |=> tbl[$past(mark_blk)]);

  // R2
  scan_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_set |=> tbl[$past(scan_blk)]);

  // R5
  busy_not_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_busy |-> !resp_bad);

endmodule

// File: rtl/bbm_counter.sv
module bbm_counter #(
  parameter int CNT_W = 12,
  localparam int MAXV = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc,
  output logic [CNT_W-1:0] count
);
  import bbm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= CNT_W'(sat_add(32'(count), 32'(inc), MAXV));
  end

  // R8
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count >= $past(count));

endmodule

// File: rtl/bad_block_map.sv
module bad_block_map #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MAIN_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int CNT_W           = 12,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             rd_req,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  input  logic             rd_done,
  input  logic [7:0]       rd_byte,
  input  logic             mark_valid,
  input  logic [BLK_W-1:0] mark_blk,
  input  logic             qry_valid,
  input  logic [BLK_W-1:0] qry_blk,
  output logic             resp_valid,
  output logic             resp_bad,
  output logic             resp_busy,
  output logic             ready,
  output logic [CNT_W-1:0] bad_count
);

  logic             scan_set;
  logic [BLK_W-1:0] scan_blk;
  logic [1:0]       new_bad;

  bbm_scanner #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
    .rd_done(rd_done), .rd_byte(rd_byte), .scan_set(scan_set),
    .scan_blk(scan_blk), .ready(ready)
  );

  bbm_table #(.NUM_BLOCKS(NUM_BLOCKS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .scan_set(scan_set), .scan_blk(scan_blk),
    .mark_valid(mark_valid), .mark_blk(mark_blk), .ready(ready),
    .qry_valid(qry_valid), .qry_blk(qry_blk), .resp_valid(resp_valid),
    .resp_bad(resp_bad), .resp_busy(resp_busy), .new_bad(new_bad)
  );

  bbm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(new_bad), .count(bad_count)
  );

  // R5
  busy_follows_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_busy == !$past(ready)));

  // R4
  no_read_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !rd_req);

endmodule

// File: tb/bad_block_map_tb.sv
module bad_block_map_tb;

  localparam int NB    = 2048;
  localparam int PPB   = 64;
  localparam int LAT   = 2;
  localparam int SAME  = 10;    // scan finds good, report lands same cycle
  localparam int DIFF  = 5;     // scan finds bad, report on EXTRA same cycle
  localparam int EXTRA = 1500;
  localparam int DURING = 1000;
  localparam int AFTER  = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // DUT signals
  logic        rd_req, rd_done, resp_valid, resp_bad, resp_busy, ready;
  logic [16:0] rd_row;
  logic [11:0] rd_col;
  logic [7:0]  rd_byte;
  logic        mark_valid, qry_valid;
  logic [10:0] mark_blk, qry_blk;
  logic [11:0] bad_count;

  logic        t_mv = 1'b0, m_mv = 1'b0, qv = 1'b0;
  logic [10:0] t_mb = '0, m_mb = '0, qb = '0;
  assign mark_valid = t_mv | m_mv;
  assign mark_blk   = m_mv ? m_mb : t_mb;
  assign qry_valid  = qv;
  assign qry_blk    = qb;

  bad_block_map u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
    .rd_done(rd_done), .rd_byte(rd_byte), .mark_valid(mark_valid),
    .mark_blk(mark_blk), .qry_valid(qry_valid), .qry_blk(qry_blk),
    .resp_valid(resp_valid), .resp_bad(resp_bad), .resp_busy(resp_busy),
    .ready(ready), .bad_count(bad_count)
  );

  // small instance for saturation: 16 blocks, 2-bit count
  logic       s_req, s_done, s_rv, s_bad, s_busy, s_ready;
  logic [5:0] s_row;
  logic [11:0] s_col;
  logic [7:0] s_byte;
  logic       s_qv = 1'b0;
  logic [3:0] s_qb = '0;
  logic [1:0] s_cnt;

  bad_block_map #(.NUM_BLOCKS(16), .PAGES_PER_BLOCK(4), .CNT_W(2)) u_sat (
    .clk(clk), .rst_n(rst_n), .rd_req(s_req), .rd_row(s_row), .rd_col(s_col),
    .rd_done(s_done), .rd_byte(s_byte), .mark_valid(1'b0), .mark_blk(4'd0),
    .qry_valid(s_qv), .qry_blk(s_qb), .resp_valid(s_rv), .resp_bad(s_bad),
    .resp_busy(s_busy), .ready(s_ready), .bad_count(s_cnt)
  );

  // R2 marker pattern the sequencer model returns
  function automatic logic [7:0] marker_of(int b);
    if (b == 0)          return 8'h00;
    if (b == NB - 1)     return 8'hFE;
    if (b % 97 == 5)     return 8'h7F;
    if (b % 131 == 3)    return 8'hF7;
    return 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // page-read sequencer model for the main instance
  int seq = 0, lat = LAT, addr_err = 0, rdy_early = 0, rdy_late = 0;
  bit last_checked = 1'b0;
  initial begin rd_done = 1'b0; rd_byte = 8'h00; end
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_done = 1'b0; lat = LAT; m_mv = 1'b0;
    end else begin
      m_mv = 1'b0;
      if (rd_done) begin
        rd_done = 1'b0; lat = LAT;
        if (seq == NB && !last_checked) begin
          last_checked = 1'b1;
          if (ready !== 1'b1) rdy_late++;
        end
      end else if (rd_req) begin
        if (lat != 0) lat--;
        else begin
          // R1 address check
          if (rd_row != 17'(seq * PPB) || rd_col != 12'd2048) addr_err++;
          rd_byte = marker_of(seq);
          rd_done = 1'b1;
          if (seq == SAME) begin m_mv = 1'b1; m_mb = 11'(SAME);  end
          if (seq == DIFF) begin m_mv = 1'b1; m_mb = 11'(EXTRA); end
          if (seq == NB - 1 && ready !== 1'b0) rdy_early++;
          seq++;
        end
      end
    end
  end

  // sequencer model for the small instance: even blocks bad
  always @(negedge clk) begin
    if (!rst_n) begin s_done = 1'b0; s_byte = 8'h00; end
    else begin
      s_byte = (s_row[2] == 1'b0) ? 8'h00 : 8'hFF;
      s_done = s_req && !s_done;
    end
  end

  task automatic lookup(input int b, output logic v, output logic isbad, output logic busy);
    @(negedge clk); qv = 1'b1; qb = 11'(b);
    @(negedge clk); qv = 1'b0;
    v = resp_valid; isbad = resp_bad; busy = resp_busy;
  endtask

  task automatic report(input int b);
    @(negedge clk); t_mv = 1'b1; t_mb = 11'(b);
    @(negedge clk); t_mv = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ready == 1'b0, "R3 ready low after reset", ready, 0);
    check(bad_count == 0, "R3 count zero after reset", bad_count, 0);
    check(rd_req == 1'b1, "R3 scan starts", rd_req, 1);
  endtask

  task automatic t_busy;
    logic v, b, y;
    lookup(NB - 1, v, b, y);
    check(v == 1'b1, "R5 resp_valid during scan", v, 1);
    check(y == 1'b1 && b == 1'b0, "R5 busy during scan", {y, b}, 2);
  endtask

  task automatic t_mark_during;
    repeat (200) @(negedge clk);
    report(DURING);   // R6 during scan
  endtask

  task automatic t_scan_done;
    while (!ready) @(negedge clk);
    @(negedge clk);
    check(seq == NB, "R1 all blocks read before ready", seq, NB);
    check(addr_err == 0, "R1 row/col of each read", addr_err, 0);
    check(rdy_early == 0, "R4 ready low at last byte", rdy_early, 0);
    check(rdy_late == 0 && last_checked, "R4 ready on last edge", rdy_late, 0);
    check(rd_req == 1'b0, "R4 no request after ready", rd_req, 0);
  endtask

  function automatic bit exp_bad(int b);
    return (marker_of(b) != 8'hFF) || b == SAME || b == EXTRA || b == DURING;
  endfunction

  task automatic t_sweep;
    int errs = 0, nbad = 0;
    logic v, b, y;
    for (int i = 0; i < NB; i++) begin
      lookup(i, v, b, y);
      if (exp_bad(i)) nbad++;
      if (!v || y || b != exp_bad(i)) errs++;
    end
    check(errs == 0, "R2 R5 map contents", errs, 0);
    lookup(0, v, b, y);
    check(b == 1'b1, "R2 block 0 marker 0x00", b, 1);
    lookup(NB - 1, v, b, y);
    check(b == 1'b1, "R2 last block marker 0xFE", b, 1);
    lookup(3, v, b, y);
    check(b == 1'b1, "R2 marker 0xF7", b, 1);
    lookup(1, v, b, y);
    check(b == 1'b0, "R2 marker 0xFF good", b, 0);
    lookup(SAME, v, b, y);
    check(b == 1'b1, "R7 same-cycle same entry bad", b, 1);
    lookup(EXTRA, v, b, y);
    check(b == 1'b1, "R7 same-cycle other entry bad", b, 1);
    lookup(DURING, v, b, y);
    check(b == 1'b1, "R6 report during scan", b, 1);
    check(bad_count == nbad, "R7 R8 count after scan", bad_count, nbad);
  endtask

  task automatic t_mark_after;
    logic v, b, y;
    int c0 = bad_count;
    report(AFTER);
    check(bad_count == c0 + 1, "R6 count after new report", bad_count, c0 + 1);
    lookup(AFTER, v, b, y);
    check(b == 1'b1 && y == 1'b0, "R6 report after ready", b, 1);
    report(0);
    check(bad_count == c0 + 1, "R6 re-report no effect", bad_count, c0 + 1);
  endtask

  task automatic t_saturate;
    int errs = 0;
    while (!s_ready) @(negedge clk);
    check(s_cnt == 2'd3, "R8 count saturates", s_cnt, 3);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); s_qv = 1'b1; s_qb = 4'(i);
      @(negedge clk); s_qv = 1'b0;
      if (!s_rv || s_busy || s_bad != ((i % 2) == 0)) errs++;
    end
    check(errs == 0, "R8 small map contents", errs, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_busy();
    t_mark_during();
    t_scan_done();
    t_sweep();
    t_mark_after();
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule